// File: doc/BRIEF.md
# Distributed-Arithmetic Four-Tap Inner Product

This block produces the output of a four-tap FIR filter, the inner product of four signed weights with the newest input sample and the three before it. It uses no multipliers. Each accepted sample is pushed into a four-deep delay line. The block then walks the sample bit positions from the least significant bit up, one per clock. At each bit position the same bit of all four stored samples forms a 4-bit address. That address selects a precomputed sum of weights from a small table. The selected sum is shifted to its bit position and folded into a carry-save accumulator. The slice of sign bits is subtracted rather than added. One carry-propagate addition then resolves the accumulator, and the result is captured on the output together with a one-cycle done flag.

Weights are written one tap at a time through a load port. The table of the fifteen nonzero weight combinations is refreshed on the same clock edge as the weight write. A conversion takes one clock per sample bit, plus one clock for the final capture. A new sample may be offered in the same clock in which the previous result is captured, so samples are accepted at a steady rate of one per SAMP_W+1 clocks.

Top module: `da_inner4`

## Requirements
- R1: While reset is asserted and after it is released, y_out is 0 and y_done is 0. The delay line and all weights clear to 0, so a conversion run before any weight load yields 0.
- R2: Samples and weights are 8-bit two's-complement integers. Each result equals w0·x[n] + w1·x[n−1] + w2·x[n−2] + w3·x[n−3], taken modulo 2^16 as a 16-bit two's-complement value.
- R3: An accepted sample becomes x[n], and the older samples move one tap down. Tap 0 always holds the newest sample, and the sample in tap 3 is dropped.
- R4: Table address bit k is the current bit of x[n−k]. The entry at address a is the sum of the weights wk whose bit k of a is 1, for example address 3 gives w0+w1. An all-zero address contributes 0 and is not stored.
- R5: The most significant bit of each sample is weighted −2^7. Its partial sum is subtracted on the last of the eight bit steps, so the most negative sample −128 is handled exactly.
- R6: If smp_valid is sampled high at a rising edge E0, y_done is high for exactly one clock, starting at edge E0+9. y_out changes only at that edge and holds its value until the next result.
- R7: smp_valid is ignored while a conversion is in its eight bit steps. The ignored sample does not reach the delay line, and neither the running result nor any later result depends on it.
- R8: wt_load is ignored while a conversion is in its eight bit steps. The weight it carries is never written.
- R9: wt_load writes wt_in into tap wt_idx, with index 0 meaning w0. A sample accepted on the same edge as the weight write, or on any later edge, already uses the new weight.
- R10: A sample offered in the clock before its predecessor's result is captured is accepted on the capture edge. This gives a cadence of one sample per 9 clocks, and both results are correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Offers smp_in as the next sample |
| smp_in | input | 8 | Two's-complement input sample |
| wt_load | input | 1 | Write strobe for one weight |
| wt_idx | input | 2 | Tap index of the weight being written |
| wt_in | input | 8 | Two's-complement weight value |
| y_out | output | 16 | Two's-complement inner product, held between results |
| y_done | output | 1 | One-clock pulse marking a new y_out |

## Verification
The hardest situations to reach from the ports are a sample or weight strobe that lands inside the eight bit steps, and a new sample accepted on the very edge that captures the previous result. In both cases the timing must fall exactly into a narrow window. The bench counts clocks from the accepting edge and raises the strobes at fixed offsets inside the run and on the capture edge. It then checks that the current result and the result after it both match a reference history that left out the rejected strobe. The sign slice and table addressing are driven to their extremes with −128 samples, impulse trains against distinct power-of-two weights, and random signed data.

// File: rtl/da4_pkg.sv
package da4_pkg;
  typedef enum logic [1:0] {
    DA_IDLE = 2'd0,
    DA_RUN  = 2'd1,
    DA_FIN  = 2'd2
  } da_state_e;
endpackage

// File: rtl/da4_delay_line.sv
module da4_delay_line #(
  parameter int TAPS   = 4,
  parameter int SAMP_W = 8,
  localparam int BIT_W = $clog2(SAMP_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [SAMP_W-1:0] smp_in,
  input  logic [BIT_W-1:0]  bit_sel,
  output logic [TAPS-1:0]   addr
);
  logic [TAPS-1:0][SAMP_W-1:0] taps_q, taps_d;

  // next state: newest sample enters tap 0, older ones move down
  always_comb begin
    taps_d = taps_q;
    if (shift_en) begin
      taps_d[0] = smp_in;
      for (int k = 1; k < TAPS; k++) taps_d[k] = taps_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= taps_d;
  end

  // address bit k is the selected bit of the sample k steps old
  always_comb begin
    for (int k = 0; k < TAPS; k++) addr[k] = taps_q[k][bit_sel];
  end
endmodule

// File: rtl/da4_psum_table.sv
module da4_psum_table #(
  parameter int TAPS   = 4,
  parameter int COEF_W = 8,
  localparam int IDX_W = $clog2(TAPS),
  localparam int NENT  = (1 << TAPS) - 1,
  localparam int PS_W  = COEF_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              busy,
  input  logic [TAPS-1:0]   addr,
  output logic [PS_W-1:0]   psum
);
  logic [TAPS-1:0][COEF_W-1:0] w_q, w_nx;
  logic [PS_W-1:0] tbl_q  [1:NENT];
  logic [PS_W-1:0] ent_nx [1:NENT];

  always_comb begin
    for (int k = 0; k < TAPS; k++)
      w_nx[k] = (wr_en && wr_idx == IDX_W'(k)) ? wr_data : w_q[k];
  end

  // every nonzero combination, built from the weights as they will be after this edge
  always_comb begin
    for (int a = 1; a <= NENT; a++) begin
      ent_nx[a] = '0;
      for (int k = 0; k < TAPS; k++) begin
        if (((a >> k) & 1) == 1)
          ent_nx[a] = ent_nx[a] + {{(PS_W-COEF_W){w_nx[k][COEF_W-1]}}, w_nx[k]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0;
      for (int a = 1; a <= NENT; a++) tbl_q[a] <= '0;
    end else if (wr_en) begin
      w_q <= w_nx;
      for (int a = 1; a <= NENT; a++) tbl_q[a] <= ent_nx[a];
    end
  end

  always_comb psum = (addr == '0) ? '0 : tbl_q[addr];

  logic [PS_W-1:0] all_sum;
  always_comb begin
    all_sum = '0;
    for (int k = 0; k < TAPS; k++)
      all_sum = all_sum + {{(PS_W-COEF_W){w_q[k][COEF_W-1]}}, w_q[k]};
  end

  // R4: the all-taps entry tracks the stored weights
  p_tbl_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_q[NENT] == all_sum);

  // R8: stored weights do not move during a conversion
  p_wt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(w_q));
endmodule

// File: rtl/da4_csa_accum.sv
module da4_csa_accum #(
  parameter int PS_W  = 10,
  parameter int OUT_W = 16,
  parameter int SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             sub,
  input  logic [SH_W-1:0]  shamt,
  input  logic [PS_W-1:0]  psum,
  output logic [OUT_W-1:0] sum_out
);
  logic [OUT_W-1:0] s_q, c_q, s_nx, c_nx, ext, op, maj;

  always_comb begin
    ext  = {{(OUT_W-PS_W){psum[PS_W-1]}}, psum} << shamt;
    op   = sub ? ~ext : ext;
    s_nx = s_q ^ c_q ^ op;
    maj  = (s_q & c_q) | (s_q & op) | (c_q & op);
    // the free carry LSB takes the +1 of the two's-complement negate
    c_nx = (maj << 1) | OUT_W'(sub);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
      c_q <= '0;
    end else if (clr) begin
      s_q <= '0;
      c_q <= '0;
    end else if (step) begin
      s_q <= s_nx;
      c_q <= c_nx;
    end
  end

  assign sum_out = s_q + c_q;
endmodule

// File: rtl/da_inner4.sv
module da_inner4 import da4_pkg::*; #(
  parameter int TAPS   = 4,
  parameter int SAMP_W = 8,
  parameter int COEF_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [SAMP_W-1:0]        smp_in,
  input  logic                     wt_load,
  input  logic [$clog2(TAPS)-1:0]  wt_idx,
  input  logic [COEF_W-1:0]        wt_in,
  output logic [OUT_W-1:0]         y_out,
  output logic                     y_done
);
  localparam int BIT_W = $clog2(SAMP_W);
  localparam int PS_W  = COEF_W + $clog2(TAPS);

  // reset: asserted at once, released after two clocks
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  da_state_e        state_q, state_d;
  logic [BIT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic             accept, running, last_bit, wt_we;
  logic [TAPS-1:0]  addr;
  logic [PS_W-1:0]  psum;
  logic [OUT_W-1:0] sum_out;
  logic [OUT_W-1:0] y_q;
  logic             done_q;

  assign running  = (state_q == DA_RUN);
  assign accept   = smp_valid && !running;
  assign wt_we    = wt_load && !running;
  assign last_bit = (bit_cnt_q == BIT_W'(SAMP_W-1));

  always_comb begin
    state_d   = state_q;
    bit_cnt_d = bit_cnt_q;
    unique case (state_q)
      DA_IDLE: if (accept) begin state_d = DA_RUN; bit_cnt_d = '0; end
      DA_RUN: begin
        bit_cnt_d = bit_cnt_q + 1'b1;
        if (last_bit) state_d = DA_FIN;
      end
      DA_FIN: begin
        state_d   = accept ? DA_RUN : DA_IDLE;
        bit_cnt_d = '0;
      end
      default: state_d = DA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q   <= DA_IDLE;
      bit_cnt_q <= '0;
      y_q       <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      done_q    <= (state_q == DA_FIN);
      if (state_q == DA_FIN) y_q <= sum_out;
    end
  end

  assign y_out  = y_q;
  assign y_done = done_q;

  da4_delay_line #(.TAPS(TAPS), .SAMP_W(SAMP_W)) u_dly (
    .clk(clk), .rst_n(rst_i), .shift_en(accept), .smp_in(smp_in),
    .bit_sel(bit_cnt_q), .addr(addr));

  da4_psum_table #(.TAPS(TAPS), .COEF_W(COEF_W)) u_tbl (
    .clk(clk), .rst_n(rst_i), .wr_en(wt_we), .wr_idx(wt_idx), .wr_data(wt_in),
    .busy(running), .addr(addr), .psum(psum));

  da4_csa_accum #(.PS_W(PS_W), .OUT_W(OUT_W), .SH_W(BIT_W)) u_acc (
    .clk(clk), .rst_n(rst_i), .clr(accept), .step(running), .sub(running && last_bit),
    .shamt(bit_cnt_q), .psum(psum), .sum_out(sum_out));

  // R6: done is a single-clock pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_i)
    y_done |=> !y_done);

  // R6: the output moves only together with done
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_i)
    !y_done |-> $stable(y_out));

  // R4: a slice of all-zero bits contributes nothing
  p_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (running && addr == '0) |-> (psum == '0));
endmodule

// File: tb/da_inner4_tb.sv
`timescale 1ns/1ps
module da_inner4_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [7:0]  smp_in;
  logic        wt_load;
  logic [1:0]  wt_idx;
  logic [7:0]  wt_in;
  logic [15:0] y_out;
  logic        y_done;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  logic signed [7:0] hist [4];
  logic signed [7:0] w_m  [4];

  always #2 clk = ~clk;

  da_inner4 dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
    .wt_load(wt_load), .wt_idx(wt_idx), .wt_in(wt_in),
    .y_out(y_out), .y_done(y_done));

  // fields: [39:32] w3, [31:24] w2, [23:16] w1, [15:8] w0, [7:0] sample
  localparam logic [39:0] VEC [14] = '{
    40'h00_00_00_00_00, 40'h08_04_02_01_01, 40'h08_04_02_01_00,
    40'h08_04_02_01_00, 40'h08_04_02_01_00, 40'h08_04_02_01_80,
    40'h7F_7F_7F_7F_80, 40'h7F_7F_7F_7F_80, 40'h80_80_80_80_80,
    40'h80_80_80_80_7F, 40'h7F_81_C0_3F_55, 40'h7F_81_C0_3F_AA,
    40'hFF_01_FF_01_FF, 40'h10_F0_20_E0_33
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_y();
    int s = 0;
    for (int k = 0; k < 4; k++) s += int'(w_m[k]) * int'(hist[k]);
    return s[15:0];
  endfunction

  function automatic void model_push(input logic [7:0] x);
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
  endfunction

  task automatic load_w(input int k, input logic [7:0] v);
    @(negedge clk);
    wt_load = 1'b1; wt_idx = 2'(k); wt_in = v;
    @(negedge clk);
    wt_load = 1'b0;
    w_m[k] = v;
  endtask

  // ends half a clock after the accepting edge
  task automatic push(input logic [7:0] x);
    @(negedge clk);
    smp_valid = 1'b1; smp_in = x;
    @(negedge clk);
    smp_valid = 1'b0;
    model_push(x);
  endtask

  task automatic conv(input logic [7:0] x, input string tag);
    push(x);
    repeat (9) @(negedge clk);
    chk("R6 done", {15'd0, y_done}, 16'd1);
    chk(tag, y_out, model_y());
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin hist[k] = '0; w_m[k] = '0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] e1;
    smp_valid = 1'b0; smp_in = '0; wt_load = 1'b0; wt_idx = '0; wt_in = '0;
    do_reset();

    // R1: reset state and zero weights
    chk("R1 y_out", y_out, 16'd0);
    chk("R1 y_done", {15'd0, y_done}, 16'd0);
    conv(8'h5A, "R1 zero weights");

    // table walk: R2 R3 R4 R5
    foreach (VEC[i]) begin
      for (int k = 0; k < 4; k++)
        if (w_m[k] !== VEC[i][8*k+8 +: 8]) load_w(k, VEC[i][8*k+8 +: 8]);
      conv(VEC[i][7:0], $sformatf("R2 R3 R4 R5 vector %0d", i));
    end

    // random signed data, weights refreshed every eight samples (R2, R9)
    for (int i = 0; i < 120; i++) begin
      if (i % 8 == 0)
        for (int k = 0; k < 4; k++) load_w(k, 8'($urandom));
      conv(8'($urandom), "R2 random");
    end

    // R7: sample strobe inside the bit steps is dropped
    push(8'h21);
    repeat (2) @(negedge clk);
    smp_valid = 1'b1; smp_in = 8'h7E;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 current", y_out, model_y());
    conv(8'hC3, "R7 following");

    // R8: weight strobe inside the bit steps is dropped
    push(8'h3C);
    repeat (4) @(negedge clk);
    wt_load = 1'b1; wt_idx = 2'd2; wt_in = w_m[2] + 8'd37;
    @(negedge clk);
    wt_load = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 current", y_out, model_y());
    conv(8'h91, "R8 following");

    // R9: weight write and sample on the same edge
    @(negedge clk);
    wt_load = 1'b1; wt_idx = 2'd0; wt_in = 8'hB5;
    smp_valid = 1'b1; smp_in = 8'h47;
    @(negedge clk);
    wt_load = 1'b0; smp_valid = 1'b0;
    w_m[0] = 8'hB5; model_push(8'h47);
    repeat (9) @(negedge clk);
    chk("R9 same edge", y_out, model_y());

    // R10: next sample accepted on the capture edge
    push(8'h66);
    e1 = model_y();
    repeat (8) @(negedge clk);
    smp_valid = 1'b1; smp_in = 8'h99;
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R10 first done", {15'd0, y_done}, 16'd1);
    chk("R10 first", y_out, e1);
    model_push(8'h99);
    repeat (9) @(negedge clk);
    chk("R10 second done", {15'd0, y_done}, 16'd1);
    chk("R10 second", y_out, model_y());
    @(negedge clk);
    chk("R6 pulse ends", {15'd0, y_done}, 16'd0);

    // R1: reset in the middle of a conversion
    push(8'h44);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset y_out", y_out, 16'd0);
    chk("R1 mid reset y_done", {15'd0, y_done}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin hist[k] = '0; w_m[k] = '0; end
    conv(8'h7F, "R1 after reset");

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule